// File: doc/BRIEF.md
# CAN bit-stream arbitration transmitter

This block is the bit-level transmit path of a CAN node. A frame that is already assembled elsewhere (start bit, identifier, remote-request flag, control, data and CRC sequence, then the delimiters and end bits) is streamed into it one raw bit at a time. Each raw bit arrives with a field tag and a last-bit marker. The block drives each bit for one bit time on the transmit pin and inserts stuff bits where the stuffing rule calls for them. At every bit-time strobe it also reads the bus level back.

The bus is wired-AND, so a dominant (low) level from any node wins. Suppose the block sends recessive during an arbitration bit and reads dominant. It has lost arbitration: it releases the bus at once and reports the loss. A mismatch elsewhere is a bit error, except in the acknowledge slot, which the block always leaves recessive for the receivers to pull low. After a loss, a bit error or the last bit, the block returns to idle with the pin recessive. It raises one single-cycle status pulse so that the frame source can retry or move on.

The frame source presents a raw bit and keeps it steady until the block pulses its advance output. That output means the raw bit has been consumed. The bit-time strobe comes from a separate bit-timing unit and marks the sample point of the bit being driven.

Top module: `can_bit_tx`

## Requirements
- R1: Out of reset and whenever idle, `tx_pin` is recessive (1), `busy` is 0 and no status pulse or advance pulse occurs, even while `bit_tick` pulses.
- R2: A `start` pulse while idle arms the block, and a `start` pulse while busy has no effect. The first `bit_tick` after arming drives the presented raw bit. From then on, each `bit_tick` that does not end the frame drives either the next raw bit or a stuff bit. Each raw bit driven is acknowledged by a one-cycle `frm_adv` pulse in the cycle after that `bit_tick`, and a stuff bit gets no `frm_adv`.
- R3: Field tags are 3-bit codes: 0 start bit, 1 arbitration (identifier and remote flag, MSB first), 2 control, 3 data, 4 CRC sequence, 5 CRC delimiter, 6 acknowledge slot, 7 ack delimiter and end of frame. In fields 0 to 4, five consecutive driven bits of equal value are followed by one stuff bit of the opposite value. That stuff bit starts a new run and carries the field tag of the bit before it. No stuffing happens in fields 5 to 7.
- R4: In the acknowledge slot (field 6), `tx_pin` is recessive whatever raw bit is presented, and a dominant level read back there raises no error.
- R5: If a non-stuff bit of field 1 is driven recessive and the bus reads dominant at its `bit_tick`, `arb_lost` pulses for one cycle in the next cycle. `tx_pin` goes recessive and `busy` clears in that same cycle. A dominant arbitration bit read back recessive raises nothing.
- R6: Any other readback mismatch, including one on a stuff bit inside field 1, makes `bit_err` pulse in the cycle after the `bit_tick`, with the bus released and `busy` cleared.
- R7: When the bit marked by `frm_last` passes its readback check, `done` pulses in the cycle after that `bit_tick`, and the block returns to idle with the pin recessive.
- R8: At most one of `arb_lost`, `bit_err`, `done` is high in any cycle, and each frame ends with exactly one of them.
- R9: While busy, `tx_pin` changes only in the cycle right after a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe at each bit-time sample point |
| start | input | 1 | Request to send the presented frame |
| frm_bit | input | 1 | Raw frame bit currently presented |
| frm_fld | input | 3 | Field tag of the presented bit (codes in R3) |
| frm_last | input | 1 | Presented bit is the last of the frame |
| bus_rx | input | 1 | Sampled bus level (0 dominant) |
| frm_adv | output | 1 | Presented raw bit consumed, show the next one |
| tx_pin | output | 1 | Transmit level (0 dominant, 1 recessive) |
| busy | output | 1 | A frame is armed or in progress |
| arb_lost | output | 1 | Pulse: arbitration lost, bus released |
| bit_err | output | 1 | Pulse: readback bit error, bus released |
| done | output | 1 | Pulse: frame sent to its last bit |

## Verification
The embedded properties watch several rules on every cycle: the idle pin stays recessive, the pin holds between strobes, the acknowledge slot is driven recessive, the status pulses are mutually exclusive, and each pulse lines up with a strobe. Inside the stuffing tracker, a property checks that a run never exceeds its limit and that a due stuff bit has the opposite value. Only the bench scenarios can show that the whole driven stream matches a stuffed copy of the frame computed independently. They also show that a forced dominant or recessive level at a chosen bit produces the right outcome at the right bit: a loss in arbitration, an error on a stuff bit or delimiter, or no reaction in exempt positions. The number of raw bits consumed is checked as well.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

  typedef enum logic [2:0] {
    FLD_SOF = 3'd0,
    FLD_ARB = 3'd1,
    FLD_CTL = 3'd2,
    FLD_DAT = 3'd3,
    FLD_CRC = 3'd4,
    FLD_CDL = 3'd5,
    FLD_ACK = 3'd6,
    FLD_END = 3'd7
  } fld_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEND = 2'd2
  } st_e;

  localparam logic RECESSIVE = 1'b1;

  // fields from the start bit through the CRC sequence are subject to stuffing
  function automatic logic in_stuff_zone(input logic [2:0] f);
    return f <= FLD_CRC;
  endfunction

endpackage

// File: rtl/can_tx_stuffer.sv
module can_tx_stuffer #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic load,
  input  logic bit_in,
  input  logic zone,
  output logic stuff_due
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run_q;
  logic          last_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q  <= '0;
      last_q <= 1'b1;
    end else if (load) begin
      if (!zone)
        run_q <= '0;
      else if (run_q != '0 && bit_in == last_q)
        run_q <= run_q + 1'b1;
      else
        run_q <= CW'(1);
      last_q <= bit_in;
    end
  end

  assign stuff_due = (run_q == CW'(RUN_LEN));

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    run_q <= CW'(RUN_LEN)); // R3

  AST_STUFF_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
    (load && stuff_due && !clr) |-> (bit_in != last_q)); // R3

endmodule

// File: rtl/can_tx_judge.sv
module can_tx_judge
  import can_tx_pkg::*;
(
  input  logic       sent,
  input  logic       heard,
  input  logic [2:0] fld,
  input  logic       is_stuff,
  output logic       lose,
  output logic       fault
);
  logic arb_bit;
  logic differ;

  always_comb begin
    arb_bit = (fld == FLD_ARB) && !is_stuff;
    differ  = (sent != heard);
    // recessive overwritten by dominant inside arbitration: give way
    lose    = arb_bit && sent && !heard;
    // arbitration bits and the ack slot are exempt from error checking
    fault   = differ && !arb_bit && (fld != FLD_ACK);
  end

endmodule

// File: rtl/can_bit_tx.sv
module can_bit_tx
  import can_tx_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       start,
  input  logic       frm_bit,
  input  logic [2:0] frm_fld,
  input  logic       frm_last,
  input  logic       bus_rx,
  output logic       frm_adv,
  output logic       tx_pin,
  output logic       busy,
  output logic       arb_lost,
  output logic       bit_err,
  output logic       done
);

  st_e        state;
  logic       tx_q;
  logic [2:0] cur_fld;
  logic       cur_stf;
  logic       cur_last;

  logic       lose, fault, stuff_due;
  logic       tick_send, proceed, finish;
  logic       drive_raw, drive_stf, raw_val, next_bit, zone_next, frame_clr;
  logic [2:0] next_fld;

  // ---------------- next-bit selection ----------------
  always_comb begin
    tick_send = (state == ST_SEND) && bit_tick;
    finish    = tick_send && (lose || fault || cur_last);
    proceed   = tick_send && !lose && !fault && !cur_last;
    drive_stf = proceed && stuff_due;
    drive_raw = ((state == ST_ARM) && bit_tick) || (proceed && !stuff_due);
    raw_val   = (frm_fld == FLD_ACK) ? RECESSIVE : frm_bit;
    next_bit  = drive_stf ? ~tx_q : raw_val;
    next_fld  = drive_stf ? cur_fld : frm_fld;
    zone_next = in_stuff_zone(next_fld);
    frame_clr = (state == ST_IDLE) && start;
  end

  can_tx_stuffer #(.RUN_LEN(RUN_LEN)) u_stuffer (
    .clk      (clk),
    .rst      (rst),
    .clr      (frame_clr),
    .load     (drive_raw || drive_stf),
    .bit_in   (next_bit),
    .zone     (zone_next),
    .stuff_due(stuff_due)
  );

  can_tx_judge u_judge (
    .sent    (tx_q),
    .heard   (bus_rx),
    .fld     (cur_fld),
    .is_stuff(cur_stf),
    .lose    (lose),
    .fault   (fault)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tx_q     <= RECESSIVE;
      cur_fld  <= FLD_SOF;
      cur_stf  <= 1'b0;
      cur_last <= 1'b0;
      frm_adv  <= 1'b0;
      arb_lost <= 1'b0;
      bit_err  <= 1'b0;
      done     <= 1'b0;
    end else begin
      frm_adv  <= drive_raw;
      arb_lost <= tick_send && lose;
      bit_err  <= tick_send && fault;
      done     <= tick_send && !lose && !fault && cur_last;
      if (drive_raw || drive_stf) begin
        tx_q     <= next_bit;
        cur_fld  <= next_fld;
        cur_stf  <= drive_stf;
        cur_last <= drive_raw && frm_last;
      end
      case (state)
        ST_IDLE: if (start) state <= ST_ARM;
        ST_ARM:  if (bit_tick) state <= ST_SEND;
        ST_SEND: begin
          if (finish) begin
            state <= ST_IDLE;
            tx_q  <= RECESSIVE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_pin = tx_q;
  assign busy   = (state != ST_IDLE);

  // ---------------- assertions ----------------
  AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_pin); // R1

  AST_ADV_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    frm_adv |-> $past(bit_tick)); // R2

  AST_ACK_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && cur_fld == FLD_ACK) |-> tx_pin); // R4

  AST_LOSS_IN_ARB: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> ($past(bit_tick) && $past(cur_fld) == FLD_ARB && tx_pin && !busy)); // R5

  AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    bit_err |-> (tx_pin && !busy)); // R6

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    done |-> (tx_pin && !busy && $past(bit_tick))); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arb_lost, bit_err, done})); // R8

  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(bit_tick)) |-> $stable(tx_pin)); // R9

endmodule

// File: tb/test_can_bit_tx.sv
module test_can_bit_tx;
  import can_tx_pkg::*;

  localparam int CLK_PER  = 10;
  localparam int TICK_GAP = 3;
  localparam int MAXR     = 160;
  localparam int MAXE     = 200;

  logic clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       start = 1'b0;
  logic       oth_drv = 1'b1;
  logic       frc_rec = 1'b0;
  logic       src_clr = 1'b0;
  logic       frm_bit, frm_last, bus_rx;
  logic [2:0] frm_fld;
  logic       frm_adv, tx_pin, busy, arb_lost, bit_err, done;

  logic       raw_b [MAXR];
  logic [2:0] raw_f [MAXR];
  int         raw_n = 0;
  logic       exp_b [MAXE];
  logic [2:0] exp_f [MAXE];
  logic       exp_s [MAXE];
  int         exp_n = 0;
  int         ridx = 0;

  int nchk = 0;
  int nfail = 0;
  bit fin = 0;

  assign bus_rx   = (tx_pin & oth_drv) | frc_rec;
  assign frm_bit  = (ridx < MAXR) ? raw_b[ridx] : 1'b1;
  assign frm_fld  = (ridx < MAXR) ? raw_f[ridx] : 3'd7;
  assign frm_last = (ridx == raw_n - 1);

  always @(posedge clk) begin
    if (src_clr) ridx <= 0;
    else if (frm_adv) ridx <= ridx + 1;
  end

  can_bit_tx i_can_bit_tx (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start),
    .frm_bit(frm_bit), .frm_fld(frm_fld), .frm_last(frm_last), .bus_rx(bus_rx),
    .frm_adv(frm_adv), .tx_pin(tx_pin), .busy(busy),
    .arb_lost(arb_lost), .bit_err(bit_err), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic push_raw(input logic b, input logic [2:0] f);
    raw_b[raw_n] = b;
    raw_f[raw_n] = f;
    raw_n++;
  endtask

  task automatic push_exp(input logic b, input logic [2:0] f, input logic s);
    exp_b[exp_n] = b;
    exp_f[exp_n] = f;
    exp_s[exp_n] = s;
    exp_n++;
  endtask

  // assemble raw bits and the expected stuffed stream (R3, R4)
  task automatic build_frame(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                             input logic [63:0] dat, input logic [14:0] crc);
    int run;
    logic lastv, v;
    raw_n = 0;
    push_raw(1'b0, FLD_SOF);
    for (int i = 10; i >= 0; i--) push_raw(id[i], FLD_ARB);
    push_raw(rtr, FLD_ARB);
    push_raw(1'b0, FLD_CTL);
    push_raw(1'b0, FLD_CTL);
    for (int i = 3; i >= 0; i--) push_raw(dlc[i], FLD_CTL);
    if (!rtr)
      for (int by = 0; by < int'(dlc); by++)
        for (int i = 7; i >= 0; i--) push_raw(dat[8*by+i], FLD_DAT);
    for (int i = 14; i >= 0; i--) push_raw(crc[i], FLD_CRC);
    push_raw(1'b1, FLD_CDL);
    push_raw(1'b0, FLD_ACK);  // dominant on purpose: the block must ignore it
    for (int i = 0; i < 8; i++) push_raw(1'b1, FLD_END);

    exp_n = 0; run = 0; lastv = 1'b1;
    for (int r = 0; r < raw_n; r++) begin
      v = (raw_f[r] == FLD_ACK) ? 1'b1 : raw_b[r];
      push_exp(v, raw_f[r], 1'b0);
      if (raw_f[r] <= FLD_CRC) begin
        if (run != 0 && v == lastv) run++;
        else run = 1;
        lastv = v;
        if (run == 5) begin
          push_exp(!v, raw_f[r], 1'b1);
          run = 1;
          lastv = !v;
        end
      end else begin
        run = 0;
      end
    end
  endtask

  function automatic logic oth_at(input int kind, input int p, input int i);
    return !((exp_f[i] == FLD_ACK) || (kind == 1 && i == p));
  endfunction

  // outcome: 0 done, 1 lost, 2 error; kind: 0 none, 1 force dominant, 2 force recessive
  task automatic predict(input int kind, input int p, output int out, output int pos);
    logic sent, bus, arb;
    out = 0; pos = exp_n - 1;
    for (int i = 0; i < exp_n; i++) begin
      sent = exp_b[i];
      bus  = (sent & oth_at(kind, p, i)) | (kind == 2 && i == p);
      if (bus != sent) begin
        arb = (exp_f[i] == FLD_ARB) && !exp_s[i];
        if (arb && sent) begin out = 1; pos = i; return; end
        if (!(arb || exp_f[i] == FLD_ACK)) begin out = 2; pos = i; return; end
      end
    end
  endtask

  function automatic int find_pos(input logic [2:0] f, input logic s, input logic v);
    for (int i = 0; i < exp_n; i++)
      if (exp_f[i] == f && exp_s[i] == s && exp_b[i] == v) return i;
    return -1;
  endfunction

  task automatic run_frame(input int kind, input int p, input bit poke, input string tag);
    int eo, ep, go, gp, bad_k, consumed;
    bit ok;
    predict(kind, p, eo, ep);
    consumed = 0;
    for (int i = 0; i <= ep; i++) if (!exp_s[i]) consumed++;
    @(negedge clk) src_clr = 1'b1;
    @(negedge clk) src_clr = 1'b0;
    oth_drv = 1'b1; frc_rec = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    tick_once();
    repeat (TICK_GAP) @(negedge clk);
    ok = 1; bad_k = -1; go = -1; gp = -1;
    for (int k = 0; k < exp_n; k++) begin
      oth_drv = oth_at(kind, p, k);
      frc_rec = (kind == 2 && k == p);
      if (ok && tx_pin !== exp_b[k]) begin ok = 0; bad_k = k; end
      if (poke && k == 3) begin
        start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
      tick_once();
      if (arb_lost || bit_err || done) begin
        chk($countones({arb_lost, bit_err, done}) == 1, "R8 single outcome",
            $countones({arb_lost, bit_err, done}), 1);
        go = done ? 0 : (arb_lost ? 1 : 2);
        gp = k;
        break;
      end
      repeat (TICK_GAP) @(negedge clk);
    end
    oth_drv = 1'b1; frc_rec = 1'b0;
    chk(ok, {tag, " R3 stuffed stream bit"}, bad_k, -1);
    chk(go == eo, {tag, (eo == 0) ? " R7 outcome" : (eo == 1) ? " R5 outcome" : " R6 outcome"}, go, eo);
    chk(gp == ep, {tag, " R5/R6/R7 outcome bit"}, gp, ep);
    chk(tx_pin === 1'b1 && busy === 1'b0, {tag, " release after outcome R6"}, {tx_pin, busy}, 2);
    @(negedge clk);
    chk(ridx == consumed, {tag, " R2 raw bits consumed"}, ridx, consumed);
    repeat (TICK_GAP) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [10:0] id;
    logic [63:0] dat;
    int kind, p, mode;
    void'($urandom(32'd24681));
    raw_b[0] = 1'b1; raw_f[0] = 3'd7; raw_n = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state and idle ticks
    chk(tx_pin === 1'b1, "R1 tx idle", tx_pin, 1);
    chk(busy === 1'b0, "R1 busy idle", busy, 0);
    tick_once();
    chk(!(arb_lost || bit_err || done || frm_adv) && tx_pin, "R1 idle tick no action",
        {arb_lost, bit_err, done, frm_adv}, 0);
    tick_once();
    chk(ridx == 0 && tx_pin === 1'b1, "R1 nothing consumed when idle", ridx, 0);

    // directed: identifier zero, heavy stuffing, ack raw dominant (R3, R4)
    build_frame(11'h000, 1'b0, 4'd0, 64'd0, 15'h0000);
    run_frame(0, -1, 1'b0, "D1 R4 zero id");
    // dominant forced on the stuff bit in arbitration (R6)
    build_frame(11'h000, 1'b0, 4'd1, 64'hA5, 15'h1234);
    run_frame(1, find_pos(FLD_ARB, 1'b1, 1'b1), 1'b0, "D2 arb stuff bit");
    // recessive identifier bit overwritten (R5), start poke while busy (R2)
    build_frame(11'h7FF, 1'b0, 4'd2, 64'hFFFF, 15'h7FFF);
    run_frame(1, 1, 1'b0, "D3 arb loss");
    build_frame(11'h5A3, 1'b1, 4'd3, 64'd0, 15'h2AAA);
    run_frame(0, -1, 1'b1, "D4 R2 start while busy");
    // recessive forced on dominant start bit (R6)
    build_frame(11'h123, 1'b0, 4'd0, 64'd0, 15'h0F0F);
    run_frame(2, 0, 1'b0, "D5 sof error");
    // recessive forced on a dominant arbitration bit: ignored (R5)
    build_frame(11'h000, 1'b0, 4'd0, 64'd0, 15'h3C3C);
    run_frame(2, 1, 1'b0, "D6 arb dominant ignored");
    // dominant on crc delimiter and on end bits (R6)
    build_frame(11'h2B4, 1'b0, 4'd8, 64'hFFFF_0000_FFFF_0000, 15'h0001);
    run_frame(1, find_pos(FLD_CDL, 1'b0, 1'b1), 1'b0, "D7 crc delimiter");
    build_frame(11'h2B4, 1'b0, 4'd4, 64'h0123_4567, 15'h4001);
    run_frame(1, exp_n - 1, 1'b0, "D8 last end bit");

    // random frames
    for (int n = 0; n < 40; n++) begin
      mode = $urandom_range(0, 3);
      id   = (mode == 0) ? 11'h000 : (mode == 1) ? 11'h7FF : 11'($urandom_range(0, 2047));
      dat  = (mode == 0) ? 64'd0 : (mode == 1) ? {64{1'b1}} : {$urandom(), $urandom()};
      build_frame(id, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 8)), dat,
                  15'($urandom_range(0, 32767)));
      kind = $urandom_range(0, 2);
      p    = $urandom_range(0, exp_n - 1);
      run_frame(kind, p, 1'($urandom_range(0, 1)), "random");
    end

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule